// File: doc/BRIEF.md
# Compand-Bit Power Meter

This block gauges the loudness of the signal that feeds a delta-modulation encoder. It never sees the analog input. It watches the encoder's serial output instead. Where the encoder produces three equal bits in a row, it is tracking a steep slope and steps up its step size. Such an event (a "compand" event) happens more often as the input gets louder, so the number of events in a fixed stretch of bits measures signal power.

Bits arrive one per valid/ready transfer. The block groups them into pages of 1024 accepted bits and counts the events in each page. At each page boundary it turns the count into a 5-bit code. The code is exact for small counts and gets coarser in steps as the count grows, which makes it roughly logarithmic. A one-cycle strobe marks each new reading, for use by the status logic. A synchronous general-reset input restarts the page.

The input is always ready except while general reset is high, so the block never applies back-pressure in normal running. A source may hold `in_valid` low for any number of cycles. Idle cycles neither advance the page nor change the history of recent bits.

Top module: `compand_power_meter`

## Requirements
- R1: After `rst_n` is released, `page_code` is 0, `page_done` is 0 and `in_ready` is 1.
- R2: `in_ready` is 0 exactly while `gen_reset` is 1. A bit is taken only on a clock edge where `in_valid` and `in_ready` are both 1. Cycles with `in_valid` low change neither the page position nor the history.
- R3: An accepted bit forms one event when it equals both of the two bits accepted before it in the same page (patterns 000 and 111). Runs that overlap count once per bit, so a run of n equal bits gives n-2 events.
- R4: A page is 1024 accepted bits. In the cycle after the edge that takes the 1024th bit, `page_done` is 1 for exactly one cycle. `page_code` changes at that same edge and then holds until the next page end or general reset.
- R5: The bit history is cleared at every page boundary, so the first two bits of a page never form an event with bits from the page before.
- R6: Counts 0 to 7 give codes 0 to 7 unchanged.
- R7: Codes 8 to 16 stand for counts 8, 10, 12, ..., 24, which are steps of 2.
- R8: Codes 17 to 24 stand for counts 32, 40, ..., 88, which are steps of 8.
- R9: Codes 25 to 31 stand for counts 128, 192, ..., 512, which are steps of 64. The internal count saturates at 512, and any page with 512 or more events gives code 31.
- R10: A count that falls between two thresholds gives the largest code whose threshold does not exceed it. For example, 9 gives 8, 31 gives 16, 100 gives 24 and 200 gives 26.
- R11: On a clock edge with `gen_reset` at 1, the page position, history and count are cleared, `page_code` becomes 0, no strobe is produced, and any bit offered in that cycle is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_reset | input | 1 | Synchronous general reset of the meter |
| in_valid | input | 1 | An encoder output bit is offered |
| in_bit | input | 1 | Encoder output bit |
| in_ready | output | 1 | Bit can be taken this cycle |
| page_code | output | 5 | Quasi-logarithmic power code of the last completed page |
| page_done | output | 1 | One-cycle strobe: a new code has been produced |

## Verification
The bench builds pages with an exact number of events, chosen to land on each threshold and just beside it: 0, 7, 8, 9, 24, 31, 32, 88, 127, 128, 511, 512 and the maximum of 1022. An encoder with an off-by-one error in any segment would report a neighbouring code. A saturating counter that wraps would report a small code for the full page. One page ends in two equal bits and the next starts with the same value. A design that carries its history across the boundary would report 1 instead of 0 there. Random pages with idle gaps show whether idle cycles move the page position, which would make the strobe arrive too early. A general reset in the middle of a page, while a bit is offered, shows whether that bit is wrongly taken or whether old history or an old code survives the reset.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  localparam int PAGE_BITS = 1024;
  localparam int RUN_LEN   = 3;
  localparam int CODE_W    = 5;
  localparam int SAT_COUNT = 512;

  // Event-count threshold for each output code (piecewise, coarser steps upward)
  function automatic int code_threshold(input int c);
    if (c < 8)       return c;
    else if (c < 17) return 8 + 2 * (c - 8);
    else if (c < 25) return 32 + 8 * (c - 17);
    else             return 128 + 64 * (c - 25);
  endfunction
endpackage

// File: rtl/cpm_run_detect.sv
module cpm_run_detect #(
  parameter int RUN_LEN = cpm_pkg::RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic take,
  input  logic bit_in,
  output logic hit
);
  localparam int HW     = RUN_LEN - 1;
  localparam int FILL_W = $clog2(RUN_LEN);

  logic [HW-1:0]     hist_q;
  logic [FILL_W-1:0] fill_q;
  logic [HW-1:0]     same;

  genvar i;
  generate
    for (i = 0; i < HW; i++) begin : g_cmp
      assign same[i] = (hist_q[i] == bit_in);
    end
  endgenerate

  assign hit = take && (fill_q == FILL_W'(HW)) && (&same);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (clear) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (take) begin
      hist_q <= {hist_q[HW-2:0], bit_in};
      if (fill_q != FILL_W'(HW)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/cpm_page_counter.sv
module cpm_page_counter #(
  parameter int PAGE_BITS = cpm_pkg::PAGE_BITS,
  parameter int SAT_COUNT = cpm_pkg::SAT_COUNT,
  localparam int IDX_W    = $clog2(PAGE_BITS),
  localparam int CNT_W    = $clog2(SAT_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             hit,
  output logic             last,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] count_q
);
  logic [IDX_W-1:0] idx_q;

  assign last  = take && (idx_q == IDX_W'(PAGE_BITS - 1));
  assign total = (count_q == CNT_W'(SAT_COUNT)) ? count_q : count_q + CNT_W'(hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      count_q <= '0;
    end else if (clear) begin
      idx_q   <= '0;
      count_q <= '0;
    end else if (take) begin
      if (last) begin
        idx_q   <= '0;
        count_q <= '0;
      end else begin
        idx_q   <= idx_q + 1'b1;
        count_q <= total;
      end
    end
  end
endmodule

// File: rtl/cpm_log_encode.sv
module cpm_log_encode #(
  parameter int CNT_W  = 10,
  parameter int CODE_W = cpm_pkg::CODE_W,
  localparam int NUM_CODES = 1 << CODE_W
) (
  input  logic [CNT_W-1:0]  count,
  output logic [CODE_W-1:0] code
);
  logic [NUM_CODES-1:0] ge;

  genvar c;
  generate
    for (c = 0; c < NUM_CODES; c++) begin : g_thr
      localparam int THR = cpm_pkg::code_threshold(c);
      assign ge[c] = ({22'd0, count} >= 32'(THR));
    end
  endgenerate

  // Thresholds rise monotonically and code 0 always passes: code = passes - 1
  always_comb begin
    code = CODE_W'($countones(ge) - 1);
  end
endmodule

// File: rtl/compand_power_meter.sv
module compand_power_meter #(
  parameter int PAGE_BITS = cpm_pkg::PAGE_BITS,
  parameter int RUN_LEN   = cpm_pkg::RUN_LEN,
  parameter int SAT_COUNT = cpm_pkg::SAT_COUNT,
  parameter int CODE_W    = cpm_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gen_reset,
  input  logic              in_valid,
  input  logic              in_bit,
  output logic              in_ready,
  output logic [CODE_W-1:0] page_code,
  output logic              page_done
);
  localparam int CNT_W = $clog2(SAT_COUNT + 1);

  logic             take, hit, page_last;
  logic [CNT_W-1:0] page_total, page_cnt;
  logic [CODE_W-1:0] enc_code;

  assign in_ready = !gen_reset;
  assign take     = in_valid && in_ready;

  cpm_run_detect #(.RUN_LEN(RUN_LEN)) i_detect (
    .clk(clk), .rst_n(rst_n), .clear(gen_reset || page_last),
    .take(take), .bit_in(in_bit), .hit(hit)
  );

  cpm_page_counter #(.PAGE_BITS(PAGE_BITS), .SAT_COUNT(SAT_COUNT)) i_count (
    .clk(clk), .rst_n(rst_n), .clear(gen_reset), .take(take), .hit(hit),
    .last(page_last), .total(page_total), .count_q(page_cnt)
  );

  cpm_log_encode #(.CNT_W(CNT_W), .CODE_W(CODE_W)) i_enc (
    .count(page_total), .code(enc_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_code <= '0;
      page_done <= 1'b0;
    end else if (gen_reset) begin
      page_code <= '0;
      page_done <= 1'b0;
    end else begin
      page_done <= page_last;
      if (page_last) page_code <= enc_code;
    end
  end
endmodule

// File: rtl/cpm_checker.sv
module cpm_checker #(
  parameter int CNT_W     = 10,
  parameter int CODE_W    = 5,
  parameter int SAT_COUNT = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gen_reset,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] page_code,
  input logic              page_done,
  input logic [CNT_W-1:0]  cnt
);
  AST_READY_GRESET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !gen_reset); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |=> !page_done); // R4
  AST_DONE_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    page_done |-> $past(in_valid && in_ready)); // R4
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!page_done && !$past(gen_reset)) |-> $stable(page_code)); // R4
  AST_GRESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reset |=> (page_code == '0 && !page_done)); // R11
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SAT_COUNT)); // R9
endmodule

bind compand_power_meter cpm_checker #(
  .CNT_W(CNT_W), .CODE_W(CODE_W), .SAT_COUNT(SAT_COUNT)
) i_chk (
  .clk(clk), .rst_n(rst_n), .gen_reset(gen_reset), .in_valid(in_valid),
  .in_ready(in_ready), .page_code(page_code), .page_done(page_done), .cnt(page_cnt)
);

// File: tb/test_compand_power_meter.sv
module test_compand_power_meter;
  logic clk = 1'b0, rst_n = 1'b0, gen_reset = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, page_done;
  logic [4:0] page_code;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  bit pg [1024];

  always #2.5 clk = ~clk;

  compand_power_meter i_compand_power_meter (
    .clk(clk), .rst_n(rst_n), .gen_reset(gen_reset), .in_valid(in_valid),
    .in_bit(in_bit), .in_ready(in_ready), .page_code(page_code), .page_done(page_done)
  );

  function automatic int exp_code(input int n);
    if (n >= 512) return 31;
    if (n >= 128) return 25 + (n - 128) / 64;
    if (n >= 88)  return 24;
    if (n >= 32)  return 17 + (n - 32) / 8;
    if (n >= 24)  return 16;
    if (n >= 8)   return 8 + (n - 8) / 2;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Page with exactly n events: a leading run of ones, then alternating bits
  task automatic build_runs(input int n);
    int start = (n > 0) ? n + 2 : 0;
    for (int i = 0; i < 1024; i++)
      pg[i] = (i < start) ? 1'b1 : (((i - start) % 2) == 1);
  endtask

  task automatic build_rand(input int flip_pct);
    bit b = 1'(($urandom % 2));
    for (int i = 0; i < 1024; i++) begin
      if (($urandom % 100) < flip_pct) b = ~b;
      pg[i] = b;
    end
  endtask

  // Send pg[0..n-1]; check strobe each cycle and the code at page end
  task automatic run_bits(input int n, input int gap_pct, input string req);
    int ev = 0, fill = 0;
    bit h1 = 0, h0 = 0;
    for (int i = 0; i < n; i++) begin
      while (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        @(negedge clk);
        check(page_done == 1'b0, "R2", page_done, 0);
      end
      in_valid = 1'b1; in_bit = pg[i];
      if (fill == 2 && h1 == pg[i] && h0 == pg[i]) ev++;
      h1 = h0; h0 = pg[i];
      if (fill < 2) fill++;
      @(negedge clk);
      in_valid = 1'b0;
      if (i == 1023) begin
        check(page_done == 1'b1, "R4 strobe", page_done, 1);
        check(int'(page_code) == exp_code(ev), req, page_code, exp_code(ev));
      end else begin
        check(page_done == 1'b0, "R4 early strobe", page_done, 0);
      end
    end
    @(negedge clk);
    check(page_done == 1'b0, "R4 strobe width", page_done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(page_code == 5'd0, "R1 code", page_code, 0);
    check(page_done == 1'b0, "R1 done", page_done, 0);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);

    // R6 R7 R8 R9 R10 directed thresholds (R3 via exact runs)
    build_runs(0);    run_bits(1024, 0, "R6 count 0");
    build_runs(1);    run_bits(1024, 0, "R6 count 1");
    build_runs(7);    run_bits(1024, 0, "R6 count 7");
    build_runs(8);    run_bits(1024, 0, "R7 count 8");
    build_runs(9);    run_bits(1024, 0, "R10 count 9");
    build_runs(24);   run_bits(1024, 0, "R7 count 24");
    build_runs(31);   run_bits(1024, 0, "R10 count 31");
    build_runs(32);   run_bits(1024, 0, "R8 count 32");
    build_runs(88);   run_bits(1024, 0, "R8 count 88");
    build_runs(100);  run_bits(1024, 0, "R10 count 100");
    build_runs(127);  run_bits(1024, 0, "R10 count 127");
    build_runs(128);  run_bits(1024, 0, "R9 count 128");
    build_runs(200);  run_bits(1024, 0, "R10 count 200");
    build_runs(511);  run_bits(1024, 0, "R9 count 511");
    build_runs(512);  run_bits(1024, 0, "R9 count 512");
    build_runs(1022); run_bits(1024, 0, "R9 saturation");

    // R5 history cleared at boundary: page ends 1,1 and next begins 1
    build_runs(0); pg[1023] = 1'b1; pg[1022] = 1'b1; pg[1021] = 1'b0;
    run_bits(1024, 0, "R5 page A");
    for (int i = 0; i < 1024; i++) pg[i] = ((i % 2) == 0);
    run_bits(1024, 0, "R5 page B");

    // R3 R2 random pages with idle gaps
    for (int k = 0; k < 8; k++) begin
      build_rand(3 + k * 12);
      run_bits(1024, (k % 2 == 1) ? 20 : 0, "R3 random page");
    end

    // R11 general reset mid-page with a bit offered
    build_runs(1022); run_bits(1024, 0, "R11 pre page");
    run_bits(500, 0, "R11 partial");
    @(negedge clk);
    gen_reset = 1'b1; in_valid = 1'b1; in_bit = 1'b1;
    #1;
    check(in_ready == 1'b0, "R11 ready low", in_ready, 0);
    check(in_ready == 1'b0, "R2 ready low", in_ready, 0);
    @(negedge clk);
    gen_reset = 1'b0; in_valid = 1'b0;
    check(page_code == 5'd0, "R11 code cleared", page_code, 0);
    check(page_done == 1'b0, "R11 no strobe", page_done, 0);
    // Fresh page begins 1,1 then alternates: expected count 0
    build_runs(0); pg[0] = 1'b1; pg[1] = 1'b1;
    for (int i = 2; i < 1024; i++) pg[i] = ((i % 2) == 0) ? 1'b0 : 1'b1;
    run_bits(1024, 0, "R11 fresh page");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule